// File: doc/BRIEF.md
# Dual-Pointer Line Delay Buffer

A synchronous line memory that holds one video or sensor line of 5,048 words, 8 bits each. A write port and a read port each run on their own clock. Each port has its own address pointer. A pointer steps forward by one on every edge where its active-low enable is asserted, and it wraps from the last word back to word zero. Each port also has an active-low pointer clear that returns that port's pointer to zero on any edge, whatever its enable is doing.

The usual use is to drive both ports from one clock, clear both pointers together, and keep both enables asserted. Every word then leaves the read port exactly one line (DEPTH cycles) after it entered the write port, which gives a fixed line delay for vertical filters. The data path has no valid/ready handshake and no back-pressure. A word offered with the write enable asserted is always stored. A read with the read enable asserted always completes. Flow control is the user's job, done by gating the enables. The pointers hold no defined value until each clear has been applied once.

Top module: `line_delay_buf`

## Requirements
- R1: On a write clock edge with `wr_en_n` low, `wr_data` is stored at the write pointer and the pointer advances by one.
- R2: On a write clock edge with `wr_en_n` high, nothing is stored and the write pointer keeps its value.
- R3: On a read clock edge with `rd_en_n` low, the word at the read pointer is loaded into the `rd_data` register and the read pointer advances by one. The word is visible after that edge.
- R4: On a read clock edge with `rd_en_n` high, the read pointer keeps its value and `rd_data` keeps its previous value.
- R5: Each pointer wraps from DEPTH-1 to 0 (default DEPTH = 5048).
- R6: With its clear input low and its enable high, a pointer becomes 0 on that edge, from any value.
- R7: With its clear input low and its enable low on the same edge, that edge's access uses address 0 and the pointer becomes 1.
- R8: A read of the address being written on the same edge (common clock) returns the word stored before that edge.
- R9: With one shared clock, both pointers cleared together and both enables held low, the word written on edge n appears on `rd_data` right after edge n+DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock, rising edge |
| wr_rst_n | input | 1 | Write pointer clear, active low, synchronous |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | WIDTH (8) | Word to store |
| rd_clk | input | 1 | Read port clock, rising edge |
| rd_rst_n | input | 1 | Read pointer clear, active low, synchronous |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | WIDTH (8) | Registered read word |

## Verification
The bench runs two full laps and part of a third with both ports in lockstep. This catches a wrap at the wrong count or a power-of-two wrap, either of which would shift the delay or return stale words. It also checks that a read and a write colliding on one address return the old word; a write-first memory would hand back the current input with no delay. It holds each enable high for several cycles and then resumes. A pointer that advanced anyway would skip words, and an output register without a hold would change while idle. It applies each clear both with and without its enable. A design that ignored the enable during a clear would re-read or overwrite address 0 on the next access instead of moving on to address 1.

// File: rtl/ldb_pkg.sv
package ldb_pkg;
  parameter int unsigned LDB_DEPTH_DEF = 5048;
  parameter int unsigned LDB_WIDTH_DEF = 8;

  function automatic int unsigned ldb_aw(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/ldb_ptr.sv
module ldb_ptr #(
  parameter int unsigned DEPTH = ldb_pkg::LDB_DEPTH_DEF,
  parameter int unsigned AW    = ldb_pkg::ldb_aw(DEPTH)
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          en_n,
  output logic [AW-1:0] acc_addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic [AW-1:0] stepped;

  // a clear forces this edge's access to address 0
  always_comb begin
    acc_addr = clr_n ? ptr_q : '0;
    stepped  = (acc_addr == LAST) ? '0 : acc_addr + 1'b1;
    ptr_d    = en_n ? acc_addr : stepped;
  end

  always_ff @(posedge clk) begin
    ptr_q <= ptr_d;
  end

  // R2 / R4: idle edge keeps the pointer
  p_hold_r2: assert property (@(posedge clk) disable iff (!clr_n)
    en_n |=> (ptr_q == $past(ptr_q)));

  // R1 / R3 / R5: enabled edge steps by one, wrapping at DEPTH-1
  p_step_r5: assert property (@(posedge clk) disable iff (!clr_n)
    !en_n |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

  // R6: clear alone lands on zero (the clear is the reset, so no disable)
  p_clear_r6: assert property (@(posedge clk)
    (!clr_n && en_n) |=> (ptr_q == '0));

  // R7: clear with access lands on one
  p_clracc_r7: assert property (@(posedge clk)
    (!clr_n && !en_n) |=> (ptr_q == ((DEPTH > 1) ? AW'(1) : '0)));
endmodule

// File: rtl/ldb_mem.sv
module ldb_mem #(
  parameter int unsigned DEPTH = ldb_pkg::LDB_DEPTH_DEF,
  parameter int unsigned WIDTH = ldb_pkg::LDB_WIDTH_DEF,
  parameter int unsigned AW    = ldb_pkg::ldb_aw(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             wr_do,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             rd_clk,
  input  logic             rd_clr_n,
  input  logic             rd_do,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_word
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_do) store[wr_addr] <= wr_word;
  end

  // registered read; old contents on a same-edge collision (R8)
  always_ff @(posedge rd_clk) begin
    if (rd_do) rd_word <= store[rd_addr];
  end

  // R4: output register holds while the read side idles
  p_rdhold_r4: assert property (@(posedge rd_clk) disable iff (!rd_clr_n)
    !rd_do |=> $stable(rd_word));
endmodule

// File: rtl/line_delay_buf.sv
module line_delay_buf #(
  parameter int unsigned DEPTH = ldb_pkg::LDB_DEPTH_DEF,
  parameter int unsigned WIDTH = ldb_pkg::LDB_WIDTH_DEF
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data
);
  localparam int unsigned AW = ldb_pkg::ldb_aw(DEPTH);

  logic [AW-1:0] w_addr;
  logic [AW-1:0] r_addr;

  ldb_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk      (wr_clk),
    .clr_n    (wr_rst_n),
    .en_n     (wr_en_n),
    .acc_addr (w_addr)
  );

  ldb_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk      (rd_clk),
    .clr_n    (rd_rst_n),
    .en_n     (rd_en_n),
    .acc_addr (r_addr)
  );

  ldb_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
    .wr_clk   (wr_clk),
    .wr_do    (!wr_en_n),
    .wr_addr  (w_addr),
    .wr_word  (wr_data),
    .rd_clk   (rd_clk),
    .rd_clr_n (rd_rst_n),
    .rd_do    (!rd_en_n),
    .rd_addr  (r_addr),
    .rd_word  (rd_data)
  );
endmodule

// File: tb/sim_line_delay_buf.sv
module sim_line_delay_buf;
  localparam int D = 5048;

  logic       clk = 1'b0;
  logic       wen_n = 1'b1, ren_n = 1'b1, wrst_n = 1'b0, rrst_n = 1'b0;
  logic [7:0] wdat = '0;
  logic [7:0] rdat;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  line_delay_buf u0 (
    .wr_clk(clk), .wr_rst_n(wrst_n), .wr_en_n(wen_n), .wr_data(wdat),
    .rd_clk(clk), .rd_rst_n(rrst_n), .rd_en_n(ren_n), .rd_data(rdat)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + (i >> 5)) ^ 8'h5A);
  endfunction

  // drive at a falling edge, return at the next falling edge
  task automatic cyc(input logic w_n, input logic r_n, input logic wc_n,
                     input logic rc_n, input logic [7:0] d);
    wen_n = w_n; ren_n = r_n; wrst_n = wc_n; rrst_n = rc_n; wdat = d;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (rdat !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, rdat, exp);
    end
  endtask

  task automatic clear_both();
    cyc(1, 1, 0, 0, 8'h00);
    cyc(1, 1, 0, 0, 8'h00);
  endtask

  // R1 R3 R6: pointers start at zero after a clear, words come back in order
  task automatic t_basic();
    logic [7:0] v [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    clear_both();
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1, v[i]);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, 1, 1, 8'h00);
      chk("R1/R3 ordered read", v[i]);
    end
  endtask

  // R2: idle write edges store nothing and do not move the pointer
  task automatic t_write_hold();
    clear_both();
    cyc(0, 1, 1, 1, 8'hA0);
    cyc(1, 1, 1, 1, 8'hEE);
    cyc(1, 1, 1, 1, 8'hEF);
    cyc(0, 1, 1, 1, 8'hA1);
    cyc(1, 0, 1, 1, 8'h00); chk("R2 word0", 8'hA0);
    cyc(1, 0, 1, 1, 8'h00); chk("R2 word1 contiguous", 8'hA1);
  endtask

  // R4: idle read edges hold output and pointer
  task automatic t_read_hold();
    clear_both();
    cyc(0, 1, 1, 1, 8'h5C);
    cyc(0, 1, 1, 1, 8'h6D);
    cyc(0, 1, 1, 1, 8'h7E);
    cyc(1, 0, 1, 1, 8'h00); chk("R3 first read", 8'h5C);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 1, 1, 1, 8'h00);
      chk("R4 output held", 8'h5C);
    end
    cyc(1, 0, 1, 1, 8'h00); chk("R4 pointer held", 8'h6D);
  endtask

  // R6 R7: clears from nonzero pointers, with and without enable
  task automatic t_clears();
    clear_both();
    cyc(0, 1, 1, 1, 8'h10);
    cyc(0, 1, 1, 1, 8'h20);
    cyc(0, 1, 1, 1, 8'h30);
    cyc(0, 1, 0, 1, 8'h99);   // clear+write: addr 0, then pointer 1
    cyc(0, 1, 1, 1, 8'h77);   // lands at addr 1
    cyc(1, 0, 1, 1, 8'h00); chk("R7 write clear uses addr0", 8'h99);
    cyc(1, 1, 1, 0, 8'h00); chk("R6 clear alone keeps output", 8'h99);
    cyc(1, 0, 1, 1, 8'h00); chk("R6 read pointer back at 0", 8'h99);
    cyc(1, 0, 1, 1, 8'h00); chk("R7 write pointer went to 1", 8'h77);
    cyc(1, 0, 1, 1, 8'h00); chk("R6 addr2 untouched", 8'h30);
    cyc(1, 0, 1, 0, 8'h00); chk("R7 clear+read uses addr0", 8'h99);
    cyc(1, 0, 1, 1, 8'h00); chk("R7 read pointer went to 1", 8'h77);
  endtask

  // R9 R5 R8: lockstep gives a DEPTH-cycle delay over wraps
  task automatic t_line_delay();
    clear_both();
    for (int i = 0; i < 2 * D + 10; i++) begin
      cyc(0, 0, 1, 1, pat(i));
      if (i == D) chk("R8 collision returns old word", pat(i - D));
      else if (i >= 2 * D) chk("R5 wrap delay", pat(i - D));
      else if (i > D) chk("R9 one-line delay", pat(i - D));
    end
    cyc(1, 1, 1, 1, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    t_basic();
    t_write_hold();
    t_read_hold();
    t_clears();
    t_line_delay();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule